// File: doc/BRIEF.md
# Iterative Signed/Unsigned Divide and Remainder Unit

This block computes the quotient or the remainder of two integers for a 64-bit packet-filter style ALU. It works one bit of quotient per clock. The caller presents a destination operand and a source operand. The source is either a register value or a 32-bit immediate. The caller also supplies the opcode nibble, the instruction's 16-bit offset field and a width flag, then pulses `start`. After a fixed number of cycles the unit raises `done` for one cycle. At that point `result` carries the 64-bit value to write back into the destination register.

In 64-bit mode both operands are used in full. In 32-bit mode only their low halves take part, and the 32-bit result, signed or not, is zero-extended into the 64-bit destination. The offset field picks between signed and unsigned arithmetic. Division by zero and the most-negative-by-minus-one case produce defined values and never trap. While an operation is in flight, further start requests are ignored.

Top module: `ebpf_divmod`

## Requirements
- R1: `opcode` 4'h9 returns the remainder. Any other value, 4'h3 being the defined one, returns the quotient.
- R2: `offset` equal to 16'd1 selects signed arithmetic. Any other offset value, 16'd0 being the defined one, selects unsigned arithmetic.
- R3: With `is64`=1 both operands are used as 64-bit values. With `is64`=0 only bits [31:0] of each operand take part.
- R4: In 32-bit mode `result[63:32]` is zero on completion, including for signed results.
- R5: With `src_is_reg`=1 the source operand is `src_val`. With `src_is_reg`=0 it is `imm`, sign-extended from bit 31 to 64 bits.
- R6: A zero divisor gives quotient 0. For the remainder it gives the dividend, truncated to bits [31:0] and zero-extended in 32-bit mode.
- R7: Signed division truncates toward zero, and a signed remainder takes the sign of the dividend.
- R8: Signed most-negative dividend divided by -1 gives the dividend as quotient and 0 as remainder, in both widths.
- R9: A start accepted at a rising edge makes `busy` high after that edge. `done` pulses for exactly one cycle after the edge W+2 edges later, where W is 64 or 32. `busy` falls together with that pulse, and `result` holds its value until the next completion.
- R10: `start` is ignored while `busy` is high. Operands presented then do not affect the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request an operation (taken only when idle) |
| opcode | input | 4 | Operation nibble: 4'h3 quotient, 4'h9 remainder |
| src_is_reg | input | 1 | 1: source is `src_val`, 0: source is `imm` |
| offset | input | 16 | Instruction offset field: 1 signed, 0 unsigned |
| is64 | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| dst_val | input | 64 | Dividend (destination register value) |
| src_val | input | 64 | Register source operand |
| imm | input | 32 | Immediate source operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Value written back to the destination |

## Verification
`busy` is due one edge after an accepted start. `done` and the new `result` are due 66 edges after that start in 64-bit mode and 34 edges after it in 32-bit mode. The bench model counts these edges down from the accepting edge. Every output is compared against the model on every falling clock edge, so a result that arrives one cycle early or late is reported as well as a wrong value. Starts issued while the unit is busy must leave both this timing and the result unchanged.

// File: rtl/ebpf_divmod.sv
module ebpf_divmod #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      opcode,
  input  logic            src_is_reg,
  input  logic [15:0]     offset,
  input  logic            is64,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN/2-1:0] imm,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int HLEN = XLEN / 2;
  localparam int CW   = $clog2(XLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_PREP, S_RUN, S_FIN} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] a_q, b_q, quo_r, div_r;
  logic [XLEN:0]   rem_r;
  logic            neg_a, neg_b, rem_q, wide_q, zero_q;

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v, input logic w, input logic s);
    return w ? v : {{HLEN{s & v[HLEN-1]}}, v[HLEN-1:0]};
  endfunction

  wire             sgn    = (offset == 16'd1);
  wire [XLEN-1:0]  src_op = src_is_reg ? src_val : {{HLEN{imm[HLEN-1]}}, imm};
  wire [XLEN-1:0]  a_in   = widen(dst_val, is64, sgn);
  wire [XLEN-1:0]  b_in   = widen(src_op, is64, sgn);
  wire             accept = start && (state == S_IDLE);

  wire [XLEN-1:0]  a_mag  = neg_a ? -a_q : a_q;
  wire [XLEN-1:0]  b_mag  = neg_b ? -b_q : b_q;

  wire [XLEN:0]    shl    = {rem_r[XLEN-1:0], quo_r[XLEN-1]};
  wire             ge     = shl >= {1'b0, div_r};

  wire [XLEN-1:0]  q_s    = (neg_a ^ neg_b) ? -quo_r : quo_r;
  wire [XLEN-1:0]  r_s    = neg_a ? -rem_r[XLEN-1:0] : rem_r[XLEN-1:0];
  wire [XLEN-1:0]  val    = zero_q ? (rem_q ? a_q : '0) : (rem_q ? r_s : q_s);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      quo_r  <= '0;
      div_r  <= '0;
      rem_r  <= '0;
      neg_a  <= 1'b0;
      neg_b  <= 1'b0;
      rem_q  <= 1'b0;
      wide_q <= 1'b0;
      zero_q <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          a_q    <= a_in;
          b_q    <= b_in;
          neg_a  <= sgn & a_in[XLEN-1];
          neg_b  <= sgn & b_in[XLEN-1];
          rem_q  <= (opcode == 4'h9);
          wide_q <= is64;
          zero_q <= (b_in == '0);
          state  <= S_PREP;
        end
        S_PREP: begin
          quo_r <= wide_q ? a_mag : {a_mag[HLEN-1:0], {HLEN{1'b0}}};
          div_r <= b_mag;
          rem_r <= '0;
          cnt   <= wide_q ? CW'(XLEN) : CW'(HLEN);
          state <= S_RUN;
        end
        S_RUN: begin
          rem_r <= ge ? (shl - {1'b0, div_r}) : shl;
          quo_r <= {quo_r[XLEN-2:0], ge};
          cnt   <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= S_FIN;
        end
        S_FIN: begin
          result <= wide_q ? val : {{HLEN{1'b0}}, val[HLEN-1:0]};
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= '0;
    else if (accept) lat <= '0;
    else if (busy)   lat <= lat + 1'b1;
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat == (wide_q ? (CW+1)'(XLEN + 2) : (CW+1)'(HLEN + 2)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  assert_hold_operands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(b_q) && $stable(rem_q) && $stable(wide_q)));

  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> result[XLEN-1:HLEN] == '0);

  assert_div_zero_quot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q && !rem_q) |-> result == '0);
endmodule

// File: tb/ebpf_divmod_tb_top.sv
module ebpf_divmod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opcode = 4'h3;
  logic        src_is_reg = 1'b1;
  logic [15:0] offset = 16'd0;
  logic        is64 = 1'b1;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        busy, done;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ebpf_divmod dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .src_is_reg(src_is_reg), .offset(offset), .is64(is64),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .busy(busy), .done(done), .result(result)
  );

  function automatic logic [63:0] ref_div(logic [3:0] op, logic [15:0] off, logic w, logic r,
                                          logic [63:0] d, logic [63:0] s, logic [31:0] im);
    logic [63:0] sv;
    logic        sg, rm;
    longint      sa, sb;
    int          a32, b32;
    logic [31:0] u32;
    sv = r ? s : {{32{im[31]}}, im};
    sg = (off == 16'd1);
    rm = (op == 4'h9);
    if (w) begin
      if (sv == 64'd0) return rm ? d : 64'd0;
      if (!sg) return rm ? d % sv : d / sv;
      if (d == 64'h8000_0000_0000_0000 && sv == '1) return rm ? 64'd0 : d;
      sa = $signed(d);
      sb = $signed(sv);
      return rm ? 64'(sa % sb) : 64'(sa / sb);
    end
    u32 = sv[31:0];
    if (u32 == 32'd0) return rm ? {32'd0, d[31:0]} : 64'd0;
    if (!sg) return {32'd0, rm ? d[31:0] % u32 : d[31:0] / u32};
    if (d[31:0] == 32'h8000_0000 && u32 == '1) return rm ? 64'd0 : {32'd0, d[31:0]};
    a32 = $signed(d[31:0]);
    b32 = $signed(u32);
    return {32'd0, rm ? 32'(a32 % b32) : 32'(a32 / b32)};
  endfunction

  // reference model, advanced on every rising edge
  bit          m_busy = 0, m_done = 0;
  int          m_cnt = 0;
  logic [63:0] m_res = '0, m_exp = '0;
  string       m_req = "R9", cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_res = m_exp;
        end
      end else if (start) begin
        m_busy = 1;
        m_cnt  = is64 ? 66 : 34;
        m_exp  = ref_div(opcode, offset, is64, src_is_reg, dst_val, src_val, imm);
        m_req  = cur_req;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R9", 64'(busy), 64'(m_busy), "busy");
      chk("R9", 64'(done), 64'(m_done), "done");
      chk(m_req, result, m_res, "result");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_op(string req, logic [3:0] op, logic [15:0] off, logic w, logic r,
                        logic [63:0] d, logic [63:0] s, logic [31:0] im, bit poke);
    @(negedge clk);
    cur_req = req;
    opcode = op; offset = off; is64 = w; src_is_reg = r;
    dst_val = d; src_val = s; imm = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R10: new request with different operands while busy
      repeat (3) @(negedge clk);
      opcode = ~op; offset = 16'd1 - off; is64 = ~w;
      dst_val = ~d; src_val = s + 64'd5; imm = ~im;
      start = 1'b1;
      repeat (4) @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", 64'(busy), 64'd0, "reset busy");
    chk("R9", 64'(done), 64'd0, "reset done");
    chk("R9", result, 64'd0, "reset result");
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quotient and remainder selection
    run_op("R1", 4'h3, 16'd0, 1, 1, 64'd100, 64'd7, 32'd0, 0);
    run_op("R1", 4'h9, 16'd0, 1, 1, 64'd100, 64'd7, 32'd0, 0);
    // R2: offset chooses signedness
    run_op("R2", 4'h3, 16'd0, 1, 1, -64'd20, 64'd3, 32'd0, 0);
    run_op("R2", 4'h3, 16'd1, 1, 1, -64'd20, 64'd3, 32'd0, 0);
    run_op("R2", 4'h3, 16'd2, 1, 1, -64'd20, 64'd3, 32'd0, 0);
    // R3: 32-bit mode ignores upper halves
    run_op("R3", 4'h3, 16'd0, 0, 1, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0007, 32'd0, 0);
    run_op("R3", 4'h9, 16'd0, 0, 1, 64'hFFFF_FFFF_0000_0064, 64'h0000_0001_0000_0007, 32'd0, 0);
    // R4: signed 32-bit result zero-extended
    run_op("R4", 4'h3, 16'd1, 0, 1, 64'h0000_0000_FFFF_FFEC, 64'd3, 32'd0, 0);
    run_op("R4", 4'h9, 16'd1, 0, 1, 64'h0000_0000_FFFF_FFEC, 64'd3, 32'd0, 0);
    // R5: immediate sign-extended, register selection
    run_op("R5", 4'h3, 16'd1, 1, 0, 64'd30, 64'd999, 32'hFFFF_FFFD, 0);
    run_op("R5", 4'h3, 16'd0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 32'hFFFF_FFFF, 0);
    run_op("R5", 4'h3, 16'd0, 1, 1, 64'd1000, 64'd10, 32'd3, 0);
    // R6: divide by zero
    run_op("R6", 4'h3, 16'd0, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0, 0);
    run_op("R6", 4'h9, 16'd1, 1, 1, 64'h1234_5678_9ABC_DEF0, 64'd0, 32'd0, 0);
    run_op("R6", 4'h9, 16'd1, 0, 1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_0000_0000, 32'd0, 0);
    run_op("R6", 4'h9, 16'd0, 1, 0, 64'h55, 64'd7, 32'd0, 0);
    // R7: truncation toward zero, remainder sign follows dividend
    run_op("R7", 4'h3, 16'd1, 1, 1, 64'd7, -64'd2, 32'd0, 0);
    run_op("R7", 4'h9, 16'd1, 1, 1, 64'd7, -64'd2, 32'd0, 0);
    run_op("R7", 4'h3, 16'd1, 1, 1, -64'd7, 64'd2, 32'd0, 0);
    run_op("R7", 4'h9, 16'd1, 1, 1, -64'd7, 64'd2, 32'd0, 0);
    // R8: most negative by minus one
    run_op("R8", 4'h3, 16'd1, 1, 1, MIN64, '1, 32'd0, 0);
    run_op("R8", 4'h9, 16'd1, 1, 1, MIN64, '1, 32'd0, 0);
    run_op("R8", 4'h3, 16'd1, 0, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 32'd0, 0);
    run_op("R8", 4'h9, 16'd1, 0, 0, 64'h0000_0000_8000_0000, 64'd0, 32'hFFFF_FFFF, 0);
    // R10: start while busy is ignored
    run_op("R10", 4'h3, 16'd0, 1, 1, 64'd123456789, 64'd1000, 32'd0, 1);
    run_op("R10", 4'h9, 16'd1, 0, 1, 64'hFFFF_FF00, 64'd7, 32'd0, 1);

    for (int i = 0; i < 150; i++) begin
      logic [63:0] d, s;
      logic [3:0]  op;
      logic [15:0] off;
      logic        w, r;
      string       tag;
      d   = {$urandom, $urandom};
      s   = ($urandom_range(0, 3) == 0) ? 64'($urandom_range(0, 9)) : {$urandom, $urandom} >> $urandom_range(0, 60);
      if ($urandom_range(0, 5) == 0) s = -s;
      op  = $urandom_range(0, 1) ? 4'h9 : 4'h3;
      off = 16'($urandom_range(0, 1));
      w   = 1'($urandom_range(0, 1));
      r   = 1'($urandom_range(0, 3) != 0);
      tag = (r && s == 0) ? "R6" : (off == 16'd1) ? "R7" : (!w) ? "R4" : "R1";
      run_op(tag, op, off, w, r, d, s, 32'($urandom), (i % 17) == 0);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule